// File: doc/BRIEF.md
# Four-Level Radix Page Table Walker

This block resolves a 48-bit virtual address into a physical address when the translation cache misses. It reads a four-level radix tree of 512-entry tables from memory. Each table entry is 8 bytes, so each table fills one 4KB frame. The tree is entered through a root frame number supplied on an input. The block issues one 8-byte read per level. Each entry it reads yields either the frame of the next table or the final mapping.

A walk stops early when a large-page bit is found in an intermediate entry. This produces a 2MB or 1GB mapping instead of a 4KB one. Rights are collected along the whole path and judged once, when the walk ends. The result port reports:
- the physical address,
- a size code, so the translation cache can install the right mask,
- a status: success, missing mapping, or rights violation.

Only one walk is in flight at a time.

Top module: `radix_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req_valid` and `res_valid` are 0.
- R2: A request is taken only when `req_ready` is 1, which holds only while no walk is in progress. A `req_valid` pulse during a walk starts no extra memory read and does not change the result of the walk in progress.
- R3: The read for the top level goes to `root_pfn*4096 + 8*va[47:39]`. Each later level reads `next_pfn*4096 + 8*index`, where `next_pfn` is entry bits 51:12 of the level above. The indices for the later levels are `va[38:30]`, `va[29:21]` and `va[20:12]`, in that order.
- R4: A walk that reaches the fourth level takes four reads. It returns `{entry[51:12], va[11:0]}` with size code 0.
- R5: If bit 7 is set in a third-level entry, the walk stops after three reads. It returns `{entry[51:21], va[20:0]}` with size code 1, and entry bits 20:12 are ignored.
- R6: If bit 7 is set in a second-level entry, the walk stops after two reads. It returns `{entry[51:30], va[29:0]}` with size code 2.
- R7: Bit 7 has no effect in a top-level entry or in a fourth-level entry.
- R8: An entry with bit 0 clear ends the walk at once with status 1 (not present). No further read is issued, and the returned address and size code are both 0.
- R9: The access type `req_kind` is encoded 0 = read, 1 = write, 2 = fetch. A write through a path where any present entry has bit 1 clear ends with status 2 (protection fault). A read through the same path ends with status 0.
- R10: With `req_user` = 1, an access through a path where any entry has bit 2 clear ends with status 2. With `req_user` = 0, the same path ends with status 0.
- R11: A fetch through a path where any entry has bit 63 set ends with status 2. A read through the same path ends with status 0.
- R12: A not-present entry gives status 1, even when a rights violation has already been collected on the path.
- R13: While `mem_req_ready` is 0, `mem_req_valid` stays 1 and `mem_req_addr` stays unchanged. `res_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken |
| req_va | input | 48 | Virtual address to translate |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for user-mode access |
| root_pfn | input | 40 | Frame number of top-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| res_valid | output | 1 | Result pulse |
| res_pa | output | 52 | Translated physical address |
| res_size | output | 2 | 0 = 4KB, 1 = 2MB, 2 = 1GB |
| res_status | output | 2 | 0 ok, 1 not present, 2 protection |

## Verification
The bench builds the walker with its default parameters: a 48-bit virtual address, four levels of 9-bit indices, a 12-bit page offset and a 52-bit physical address. At these values, all three leaf depths and the early termination at every level can be reached with just four small tables placed in low memory. Memory latency is varied, and a mode that stalls the request handshake exercises the hold behaviour. Rights bits are placed at different levels of the path, which confirms that they combine across the whole path and are not taken from the leaf alone.

// File: rtl/radix_walker.sv
module radix_walker #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  input  logic [PA_W-OFF_W-1:0] root_pfn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              res_valid,
  output logic [PA_W-1:0]   res_pa,
  output logic [1:0]        res_size,
  output logic [1:0]        res_status
);
  localparam int PFN_W = PA_W - OFF_W;
  localparam int LVL_W = $clog2(LEVELS);
  localparam int ENT_SH = OFF_W - IDX_W;
  localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);
  localparam logic [1:0] K_WRITE = 2'd1, K_FETCH = 2'd2;
  localparam logic [1:0] ST_OK = 2'd0, ST_NP = 2'd1, ST_PROT = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;

  state_t             state;
  logic [LVL_W-1:0]   lvl;
  logic [VA_W-1:0]    va_q;
  logic [1:0]         kind_q;
  logic               user_q;
  logic [PFN_W-1:0]   base_q;
  logic               may_w, may_u, no_x;
  logic [PA_W-1:0]    pa_q;
  logic [1:0]         size_q, stat_q;

  logic [IDX_W-1:0]   idx;
  logic               present, big, leaf, w_n, u_n, x_n, prot;
  logic [PA_W-1:0]    lmask, leaf_pa, va_ext;
  int unsigned        sh;

  wire unused_bits = ^{mem_rsp_data[62:PA_W], mem_rsp_data[6:3]};

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_ISSUE);
  assign mem_req_addr  = {base_q, idx, {ENT_SH{1'b0}}};
  assign res_valid     = (state == S_DONE);
  assign res_pa        = pa_q;
  assign res_size      = size_q;
  assign res_status    = stat_q;

  assign va_ext = {{(PA_W-VA_W){1'b0}}, va_q};

  always_comb begin
    sh      = OFF_W + IDX_W * (LEVELS - 1 - int'(lvl));
    idx     = va_q[sh +: IDX_W];
    present = mem_rsp_data[0];
    w_n     = may_w & mem_rsp_data[1];
    u_n     = may_u & mem_rsp_data[2];
    x_n     = no_x | mem_rsp_data[63];
    big     = mem_rsp_data[7] && (lvl != '0) && (lvl != LAST);
    leaf    = big || (lvl == LAST);
    prot    = ((kind_q == K_WRITE) && !w_n) || (user_q && !u_n) ||
              ((kind_q == K_FETCH) && x_n);
    lmask   = (PA_W'(1) << sh) - PA_W'(1);
    leaf_pa = ({mem_rsp_data[PA_W-1:OFF_W], {OFF_W{1'b0}}} & ~lmask) |
              (va_ext & lmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      lvl    <= '0;
      va_q   <= '0;
      kind_q <= '0;
      user_q <= 1'b0;
      base_q <= '0;
      may_w  <= 1'b1;
      may_u  <= 1'b1;
      no_x   <= 1'b0;
      pa_q   <= '0;
      size_q <= '0;
      stat_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          state  <= S_ISSUE;
          lvl    <= '0;
          va_q   <= req_va;
          kind_q <= req_kind;
          user_q <= req_user;
          base_q <= root_pfn;
          may_w  <= 1'b1;
          may_u  <= 1'b1;
          no_x   <= 1'b0;
        end
        S_ISSUE: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!present) begin
            state  <= S_DONE;
            pa_q   <= '0;
            size_q <= '0;
            stat_q <= ST_NP;
          end else if (leaf) begin
            state  <= S_DONE;
            pa_q   <= prot ? '0 : leaf_pa;
            size_q <= prot ? 2'd0 : 2'(LAST - lvl);
            stat_q <= prot ? ST_PROT : ST_OK;
          end else begin
            state  <= S_ISSUE;
            lvl    <= lvl + 1'b1;
            base_q <= mem_rsp_data[PA_W-1:OFF_W];
            may_w  <= w_n;
            may_u  <= u_n;
            no_x   <= x_n;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module radix_walker_props #(
  parameter int PA_W = 52
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            res_valid,
  input logic [PA_W-1:0] res_pa,
  input logic [1:0]      res_size,
  input logic [1:0]      res_status
);
  p_hold_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  p_res_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || res_valid) |-> !req_ready);
  p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_status != 2'd0) |-> (res_pa == '0) && (res_size == 2'd0));
  p_size_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_size != 2'd3) && (res_status != 2'd3));
  p_no_read_at_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_req_valid);
endmodule

bind radix_walker radix_walker_props #(.PA_W(PA_W)) u_props (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .res_valid(res_valid), .res_pa(res_pa),
  .res_size(res_size), .res_status(res_status)
);

// File: tb/sim_radix_walker.sv
`timescale 1ns/1ps
module sim_radix_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic [39:0] root_pfn = 40'd1;
  logic        mem_req_valid, mem_req_ready = 1'b1;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid;
  logic [51:0] res_pa;
  logic [1:0]  res_size, res_status;

  always #5 clk = ~clk;

  radix_walker u0 (.*);

  localparam logic [63:0] F_P = 64'h1, F_W = 64'h2, F_U = 64'h4,
                          F_PS = 64'h80, F_NX = 64'h8000_0000_0000_0000;
  localparam logic [63:0] F_ALL = F_P | F_W | F_U;

  logic [63:0] mem [0:4095];
  int checks = 0, errors = 0;
  int reads = 0, lat = 1, cnt = 0, stall_mode = 0, cyc = 0;
  logic [51:0] rd_addr [0:7];
  logic [63:0] pend_data;

  function automatic logic [63:0] pte(input logic [39:0] pfn, input logic [63:0] fl);
    return {12'b0, pfn, 12'b0} | fl;
  endfunction

  function automatic logic [47:0] mkva(input int a, input int b, input int c,
                                       input int d, input int off);
    return {9'(a), 9'(b), 9'(c), 9'(d), 12'(off)};
  endfunction

  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pend_data;
      end
    end
    mem_req_ready = (stall_mode != 0) ? ((cyc % 3) == 0) : 1'b1;
    if (mem_req_valid && mem_req_ready) begin
      if (reads < 8) rd_addr[reads] = mem_req_addr;
      reads++;
      pend_data = mem[mem_req_addr[14:3]];
      cnt = lat + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  task automatic walk(input logic [47:0] va, input logic [1:0] kind, input logic user,
                      output logic [51:0] pa, output logic [1:0] sz,
                      output logic [1:0] st, output int nrd);
    int guard;
    @(negedge clk);
    reads = 0;
    req_va = va; req_kind = kind; req_user = user; req_valid = 1'b1;
    do @(negedge clk); while (req_ready);
    req_valid = 1'b0;
    guard = 0;
    while (!res_valid && guard < 500) begin @(negedge clk); guard++; end
    pa = res_pa; sz = res_size; st = res_status; nrd = reads;
  endtask

  task automatic clear_mem;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
  endtask

  task automatic base_tree;
    clear_mem();
    mem[1*512 + 3] = pte(40'd2, F_ALL);
    mem[2*512 + 5] = pte(40'd3, F_ALL);
    mem[3*512 + 7] = pte(40'd4, F_ALL);
    mem[4*512 + 9] = pte(40'hABCDE, F_ALL);
  endtask

  logic [47:0] va0;
  initial va0 = mkva(3, 5, 7, 9, 12'h123);

  task automatic t_reset;
    chk("R1 req_ready", req_ready, 1);
    chk("R1 mem_req_valid", mem_req_valid, 0);
    chk("R1 res_valid", res_valid, 0);
  endtask

  task automatic t_4k;
    logic [51:0] pa; logic [1:0] sz, st; int n;
    base_tree();
    walk(va0, 2'd0, 1'b1, pa, sz, st, n);
    chk("R4 pa", pa, {40'hABCDE, 12'h123});
    chk("R4 size", sz, 0);
    chk("R4 status", st, 0);
    chk("R4 reads", n, 4);
    chk("R3 addr0", rd_addr[0], 52'h1000 + 3*8);
    chk("R3 addr1", rd_addr[1], 52'h2000 + 5*8);
    chk("R3 addr2", rd_addr[2], 52'h3000 + 7*8);
    chk("R3 addr3", rd_addr[3], 52'h4000 + 9*8);
  endtask

  task automatic t_2m;
    logic [51:0] pa; logic [1:0] sz, st; int n;
    base_tree();
    mem[3*512 + 7] = pte(40'h12345, F_ALL | F_PS);
    walk(va0, 2'd0, 1'b0, pa, sz, st, n);
    chk("R5 pa", pa, {31'(40'h12345 >> 9), va0[20:0]});
    chk("R5 size", sz, 1);
    chk("R5 reads", n, 3);
  endtask

  task automatic t_1g;
    logic [51:0] pa; logic [1:0] sz, st; int n;
    base_tree();
    mem[2*512 + 5] = pte(40'h7FFFF, F_ALL | F_PS);
    walk(va0, 2'd0, 1'b0, pa, sz, st, n);
    chk("R6 pa", pa, {22'(40'h7FFFF >> 18), va0[29:0]});
    chk("R6 size", sz, 2);
    chk("R6 reads", n, 2);
  endtask

  task automatic t_ps_ignored;
    logic [51:0] pa; logic [1:0] sz, st; int n;
    base_tree();
    mem[1*512 + 3] = pte(40'd2, F_ALL | F_PS);
    mem[4*512 + 9] = pte(40'hABCDE, F_ALL | F_PS);
    walk(va0, 2'd0, 1'b0, pa, sz, st, n);
    chk("R7 reads", n, 4);
    chk("R7 pa", pa, {40'hABCDE, 12'h123});
    chk("R7 size", sz, 0);
  endtask

  task automatic t_not_present;
    logic [51:0] pa; logic [1:0] sz, st; int n;
    base_tree();
    mem[3*512 + 7] = pte(40'd4, F_W | F_U);
    walk(va0, 2'd0, 1'b0, pa, sz, st, n);
    chk("R8 status", st, 1);
    chk("R8 reads", n, 3);
    chk("R8 pa", pa, 0);
    base_tree();
    mem[1*512 + 3] = '0;
    walk(va0, 2'd0, 1'b0, pa, sz, st, n);
    chk("R8 top status", st, 1);
    chk("R8 top reads", n, 1);
  endtask

  task automatic t_write;
    logic [51:0] pa; logic [1:0] sz, st; int n;
    base_tree();
    mem[2*512 + 5] = pte(40'd3, F_P | F_U);
    walk(va0, 2'd1, 1'b0, pa, sz, st, n);
    chk("R9 write status", st, 2);
    chk("R9 write pa", pa, 0);
    walk(va0, 2'd0, 1'b0, pa, sz, st, n);
    chk("R9 read status", st, 0);
  endtask

  task automatic t_user;
    logic [51:0] pa; logic [1:0] sz, st; int n;
    base_tree();
    mem[4*512 + 9] = pte(40'hABCDE, F_P | F_W);
    walk(va0, 2'd0, 1'b1, pa, sz, st, n);
    chk("R10 user status", st, 2);
    walk(va0, 2'd1, 1'b0, pa, sz, st, n);
    chk("R10 supervisor status", st, 0);
  endtask

  task automatic t_nx;
    logic [51:0] pa; logic [1:0] sz, st; int n;
    base_tree();
    mem[1*512 + 3] = pte(40'd2, F_ALL | F_NX);
    walk(va0, 2'd2, 1'b1, pa, sz, st, n);
    chk("R11 fetch status", st, 2);
    walk(va0, 2'd0, 1'b1, pa, sz, st, n);
    chk("R11 read status", st, 0);
  endtask

  task automatic t_prio;
    logic [51:0] pa; logic [1:0] sz, st; int n;
    base_tree();
    mem[1*512 + 3] = pte(40'd2, F_P | F_U);
    mem[4*512 + 9] = '0;
    walk(va0, 2'd1, 1'b0, pa, sz, st, n);
    chk("R12 status", st, 1);
  endtask

  task automatic t_stall;
    logic [51:0] pa; logic [1:0] sz, st; int n;
    base_tree();
    stall_mode = 1; lat = 3;
    walk(va0, 2'd0, 1'b0, pa, sz, st, n);
    chk("R13 pa", pa, {40'hABCDE, 12'h123});
    chk("R13 reads", n, 4);
    @(negedge clk);
    chk("R13 pulse", res_valid, 0);
    stall_mode = 0; lat = 1;
  endtask

  task automatic t_busy;
    logic [1:0] st;
    base_tree();
    lat = 4;
    @(negedge clk);
    reads = 0;
    req_va = va0; req_kind = 2'd0; req_user = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 ready busy", req_ready, 0);
    req_va = mkva(1, 1, 1, 1, 0); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    st = res_status;
    chk("R2 result pa", res_pa, {40'hABCDE, 12'h123});
    chk("R2 status", st, 0);
    repeat (10) @(negedge clk);
    chk("R2 reads", reads, 4);
    lat = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_4k();
    t_2m();
    t_1g();
    t_ps_ignored();
    t_not_present();
    t_write();
    t_user();
    t_nx();
    t_prio();
    t_stall();
    t_busy();
    repeat (5) @(negedge clk);
    report();
  end
endmodule